// File: doc/BRIEF.md
# Lane Activity Watcher with Change Interrupt

This block watches a set of serial data lanes and reports, per lane, whether it has been toggling. Every lane feeds a small transition counter in the fast system clock domain. A slow, asynchronous monitor strobe is synchronized into that domain. On each of its rising edges, the block copies every counter's verdict into a bank of read-only status registers and restarts every counter.

A status bit of 1 marks a quiet lane. Whenever a sample changes the value of a status register, that register is flagged as pending and the active-low interrupt output goes low. A host finds the affected lanes by reading registers through a simple read port. Reading a register drops its pending flag but leaves its contents as they were. The interrupt releases only after every pending register has been read.

Top module: `activity_watch`

## Requirements
- R1: A lane with two or more transitions since its counter was last restarted reports 0 at the next sample. A lane with zero or one transition reports 1.
- R2: Status registers change only when a synchronized rising edge of `monClk` arrives. Between samples they hold their values, even while lanes toggle. At each sample the counters restart.
- R3: Address 0x22+k (k = 0..7) holds lanes 4k..4k+3, with the lowest lane in bit 0. Address 0x2A holds lanes 32 and 33 in bits 1:0. Unused upper bits of `rdData` read 0.
- R4: `rdData` takes the addressed value at the clock edge that samples `rdEn` high. A read of any address outside 0x22..0x2A returns 0.
- R5: After reset, every status bit is 1, no register is pending and `irqN` is high.
- R6: A sample that changes the value of a status register sets that register's pending flag. `irqN` is low whenever any register is pending.
- R7: Reading a pending register clears its pending flag. The read does not alter the stored status.
- R8: With several registers pending, `irqN` stays low until each of them has been read.
- R9: If a read of a register and a change of that same register fall on the same cycle, the read returns the old value and the register stays pending.
- R10: A sample that changes no register raises no new pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneIn | input | 34 | Monitored data lanes (asynchronous) |
| monClk | input | 1 | Slow monitor strobe; rising edge takes a sample |
| rdEn | input | 1 | Register read request |
| rdAddr | input | 6 | Register read address |
| rdData | output | 6 | Read data, registered |
| irqN | output | 1 | Interrupt, low while any register is pending |

## Verification
Lanes are driven with zero, one, two and three transitions per window. This shows that the activity threshold sits between one and two transitions. Single lanes are toggled in different register groups and at bit positions 0, 1 and the last lane of the 2-bit register, which separates lane-to-bit mapping errors from address decode errors. Sample sequences that do not change the status, that switch lanes to quiet, and that change several registers at once distinguish change detection from plain level reporting. A read timed to land on the same cycle as a sample exercises the pending-flag priority.

// File: rtl/actwatch_pkg.sv
package actwatch_pkg;

  localparam int IDX_W = 6;

  typedef struct packed {
    logic             sample;
    logic             rdStrobe;
    logic             rdHit;
    logic [IDX_W-1:0] rdIdx;
  } actwatch_strobes_t;

endpackage

// File: rtl/actwatch_ctrl.sv
module actwatch_ctrl
  import actwatch_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BASE_ADDR   = 34,
  parameter int NUM_REGS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              monClk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output actwatch_strobes_t stb
);

  localparam int LAST_ADDR = BASE_ADDR + NUM_REGS - 1;

  logic [SYNC_STAGES-1:0] monSync;
  logic                   monLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      monSync <= '0;
      monLast <= 1'b0;
    end else begin
      monSync <= {monSync[SYNC_STAGES-2:0], monClk};
      monLast <= monSync[SYNC_STAGES-1];
    end
  end

  logic inRange;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    inRange = (int'(rdAddr) >= BASE_ADDR) && (int'(rdAddr) <= LAST_ADDR);
    offset  = rdAddr - ADDR_W'(BASE_ADDR);
  end

  always_comb begin
    stb          = '0;
    stb.sample   = monSync[SYNC_STAGES-1] & ~monLast;
    stb.rdStrobe = rdEn;
    stb.rdHit    = rdEn & inRange;
    stb.rdIdx    = IDX_W'(offset);
  end

endmodule

// File: rtl/actwatch_datapath.sv
module actwatch_datapath
  import actwatch_pkg::*;
#(
  parameter int NUM_LANES   = 34,
  parameter int GROUP       = 4,
  parameter int NUM_REGS    = 9,
  parameter int DATA_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int ACT_EDGES   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LANES-1:0] laneIn,
  input  actwatch_strobes_t    stb,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqN,
  output logic [NUM_LANES-1:0] statusBits,
  output logic [NUM_REGS-1:0]  pendingBits
);

  localparam int CNT_W = $clog2(ACT_EDGES + 1);

  // lane synchronizers and edge detection
  logic [NUM_LANES-1:0] laneSync [SYNC_STAGES];
  logic [NUM_LANES-1:0] laneLast;
  logic [NUM_LANES-1:0] laneEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) laneSync[s] <= '0;
      laneLast <= '0;
    end else begin
      laneSync[0] <= laneIn;
      for (int s = 1; s < SYNC_STAGES; s++) laneSync[s] <= laneSync[s-1];
      laneLast <= laneSync[SYNC_STAGES-1];
    end
  end

  assign laneEdge = laneSync[SYNC_STAGES-1] ^ laneLast;

  // per-lane saturating transition counters
  logic [NUM_LANES-1:0] laneQuiet;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [CNT_W-1:0] hitCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hitCnt <= '0;
      end else if (stb.sample) begin
        hitCnt <= laneEdge[l] ? CNT_W'(1) : '0;
      end else if (laneEdge[l] && (int'(hitCnt) < ACT_EDGES)) begin
        hitCnt <= hitCnt + CNT_W'(1);
      end
    end

    assign laneQuiet[l] = (int'(hitCnt) < ACT_EDGES);
  end

  // status bank and change detection
  logic [NUM_LANES-1:0] statusQ;
  logic [NUM_LANES-1:0] statusDiff;
  logic [NUM_REGS-1:0]  regChanged;

  assign statusDiff = laneQuiet ^ statusQ;

  always_comb begin
    regChanged = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      regChanged[i/GROUP] = regChanged[i/GROUP] | statusDiff[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '1;
    end else if (stb.sample) begin
      statusQ <= laneQuiet;
    end
  end

  // pending flags, new change wins over a read
  logic [NUM_REGS-1:0] pendQ;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic readMe;
    assign readMe = stb.rdHit && (int'(stb.rdIdx) == g);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[g] <= 1'b0;
      end else if (stb.sample && regChanged[g]) begin
        pendQ[g] <= 1'b1;
      end else if (readMe) begin
        pendQ[g] <= 1'b0;
      end
    end
  end

  // read mux
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (stb.rdHit && ((i / GROUP) == int'(stb.rdIdx))) begin
        rdNext[i % GROUP] = statusQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdStrobe) begin
      rdData <= rdNext;
    end
  end

  assign irqN        = ~(|pendQ);
  assign statusBits  = statusQ;
  assign pendingBits = pendQ;

endmodule

// File: rtl/activity_watch.sv
module activity_watch
  import actwatch_pkg::*;
#(
  parameter int NUM_LANES   = 34,
  parameter int GROUP       = 4,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 6,
  parameter int BASE_ADDR   = 34,
  parameter int SYNC_STAGES = 2,
  parameter int ACT_EDGES   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LANES-1:0] laneIn,
  input  logic                 monClk,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqN
);

  localparam int NUM_REGS = (NUM_LANES + GROUP - 1) / GROUP;

  actwatch_strobes_t    ctrlStb;
  logic [NUM_LANES-1:0] statusBits;
  logic [NUM_REGS-1:0]  pendingBits;

  actwatch_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .monClk(monClk),
    .rdEn(rdEn), .rdAddr(rdAddr), .stb(ctrlStb)
  );

  actwatch_datapath #(
    .NUM_LANES(NUM_LANES), .GROUP(GROUP), .NUM_REGS(NUM_REGS),
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .ACT_EDGES(ACT_EDGES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .laneIn(laneIn), .stb(ctrlStb),
    .rdData(rdData), .irqN(irqN),
    .statusBits(statusBits), .pendingBits(pendingBits)
  );

endmodule

// File: rtl/actwatch_checker.sv
module actwatch_checker #(
  parameter int NUM_LANES = 34,
  parameter int NUM_REGS  = 9,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 6,
  parameter int BASE_ADDR = 34
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sample,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    rdAddr,
  input logic [DATA_W-1:0]    rdData,
  input logic                 irqN,
  input logic [NUM_LANES-1:0] statusBits,
  input logic [NUM_REGS-1:0]  pendingBits
);

  logic inRange;
  assign inRange = (int'(rdAddr) >= BASE_ADDR) && (int'(rdAddr) < BASE_ADDR + NUM_REGS);

  // one-hot of a read that had no competing sample
  logic [NUM_REGS-1:0] readMaskQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readMaskQ <= '0;
    end else begin
      for (int g = 0; g < NUM_REGS; g++) begin
        readMaskQ[g] <= rdEn && inRange && !sample &&
                        (int'(rdAddr) - BASE_ADDR == g);
      end
    end
  end

  assert_status_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sample |=> $stable(statusBits));

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(sample));

  assert_pend_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!sample && !rdEn) |=> $stable(pendingBits));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|readMaskQ) |-> ((pendingBits & readMaskQ) == '0));

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !inRange) |=> (rdData == '0));

endmodule

bind activity_watch actwatch_checker #(
  .NUM_LANES(NUM_LANES), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) i_actwatch_checker (
  .clk(clk), .rstN(rstN), .sample(ctrlStb.sample), .rdEn(rdEn),
  .rdAddr(rdAddr), .rdData(rdData), .irqN(irqN),
  .statusBits(statusBits), .pendingBits(pendingBits)
);

// File: tb/test_activity_watch.sv
`timescale 1ns/1ps
module test_activity_watch;

  localparam int NL = 34;
  localparam int NR = 9;
  localparam int BASE = 34;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] laneIn = '0;
  logic          monClk = 1'b0;
  logic          rdEn = 1'b0;
  logic [5:0]    rdAddr = '0;
  logic [5:0]    rdData;
  logic          irqN;

  always #2 clk = ~clk;

  activity_watch i_activity_watch (
    .clk(clk), .rstN(rstN), .laneIn(laneIn), .monClk(monClk),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irqN(irqN)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference model
  int       hits [NL];
  bit       expStat [NL];
  bit       expPend [NR];

  logic [5:0] expQ [$];
  string      tagQ [$];

  function automatic logic [5:0] regVal(int g);
    logic [5:0] v = '0;
    for (int i = 0; i < NL; i++) if (i / 4 == g) v[i % 4] = expStat[i];
    return v;
  endfunction

  function automatic bit anyPend();
    bit a = 0;
    for (int g = 0; g < NR; g++) a |= expPend[g];
    return a;
  endfunction

  task automatic check(string tag, logic [5:0] got, logic [5:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic toggle(int lane, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) laneIn[lane] = ~laneIn[lane];
      repeat (3) @(negedge clk);
      hits[lane]++;
    end
  endtask

  task automatic modelSample();
    bit nxt [NL];
    bit chg [NR];
    for (int g = 0; g < NR; g++) chg[g] = 0;
    for (int i = 0; i < NL; i++) begin
      nxt[i] = (hits[i] < 2);
      if (nxt[i] != expStat[i]) chg[i / 4] = 1;
      expStat[i] = nxt[i];
      hits[i] = 0;
    end
    for (int g = 0; g < NR; g++) if (chg[g]) expPend[g] = 1;
  endtask

  task automatic monPulse();
    repeat (3) @(negedge clk);
    monClk = 1'b1;
    repeat (5) @(negedge clk);
    monClk = 1'b0;
    repeat (4) @(negedge clk);
    modelSample();
  endtask

  task automatic readReg(int addr, string tag);
    @(negedge clk);
    rdEn = 1'b1;
    rdAddr = 6'(addr);
    if (addr >= BASE && addr < BASE + NR) begin
      expQ.push_back(regVal(addr - BASE));
      expPend[addr - BASE] = 0;
    end else begin
      expQ.push_back(6'h00);
    end
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  // read lands on the cycle the sample updates the bank
  task automatic readOnSample(int addr, string tag);
    repeat (3) @(negedge clk);
    monClk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rdEn = 1'b1;
    rdAddr = 6'(addr);
    expQ.push_back(regVal(addr - BASE));
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
    repeat (3) @(negedge clk);
    monClk = 1'b0;
    repeat (4) @(negedge clk);
    modelSample();
  endtask

  task automatic checkIrq(string tag);
    @(negedge clk);
    check(tag, {5'b0, irqN}, {5'b0, ~anyPend()});
  endtask

  // monitor: pops expected read data as results appear
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL R4: unexpected read result %h", rdData);
        end else begin
          check(tagQ.pop_front(), rdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin hits[i] = 0; expStat[i] = 1; end
    for (int g = 0; g < NR; g++) expPend[g] = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R5: reset state
    checkIrq("R5 irq after reset");
    readReg(BASE + 0, "R5 reg0 after reset");
    readReg(BASE + 8, "R5 R3 narrow reg after reset");

    // R1 R3 R6: thresholds and mapping
    toggle(0, 2);
    toggle(5, 3);
    toggle(33, 2);
    toggle(9, 1);
    monPulse();
    checkIrq("R6 irq after change");
    readReg(BASE + 0, "R1 R3 lane0 bit0");
    checkIrq("R8 still pending");
    readReg(BASE + 1, "R1 R3 lane5 bit1");
    readReg(BASE + 2, "R1 single toggle stays quiet");
    checkIrq("R8 narrow reg still pending");
    readReg(BASE + 8, "R3 lane33 bit1");
    checkIrq("R7 all read irq clear");
    readReg(BASE + 0, "R7 contents kept after read");

    // R2: toggling without a sample leaves the bank alone
    toggle(1, 2);
    readReg(BASE + 0, "R2 hold between samples");
    checkIrq("R2 no irq without sample");
    monPulse();
    checkIrq("R6 irq after second change");
    readReg(BASE + 0, "R1 lane1 active lane0 quiet");
    readReg(BASE + 1, "R1 lane5 back to quiet");
    readReg(BASE + 8, "R1 lane33 back to quiet");
    checkIrq("R7 irq clear after reads");

    // R10: unchanged samples raise nothing
    monPulse();
    monPulse();
    readReg(BASE + 0, "R10 reg0 idle");
    checkIrq("R10 no new pending");

    // R4: out-of-range reads
    readReg(BASE + 9, "R4 above range");
    readReg(0, "R4 below range");
    readReg(BASE - 1, "R4 just below range");

    // R9: read collides with a change of the same register
    toggle(20, 2);
    readOnSample(BASE + 5, "R9 read returns old value");
    checkIrq("R9 pending kept");
    readReg(BASE + 5, "R9 new value after collision");
    checkIrq("R9 irq clear after reread");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule